// File: doc/BRIEF.md
# Idle-Line Wakeup Controller

This block sits next to a serial receiver on a multi-drop line and lets a node sleep through messages addressed to other nodes. Software raises a sleep strobe once it decides the current message is not for it. While asleep, the set events of the receiver status flags are blocked before they reach the sticky flags. The block also watches the line for a gap. After a received character, it counts bit-time ticks during which the line sits at the idle (high) level. When a full character time of idle has passed, the block clears the sleep bit by itself, so the node is awake for the first character of the next message.

The length of a character time follows the frame format: a base of ten bit times (start, eight data, one stop), plus one for nine-bit data and plus one for a second stop bit. A wake-idle control input selects how the idle flag behaves. With the control at 0, the gap that wakes a sleeping node stays silent. With the control at 1, every detected gap is reported, asleep or not. Other status set events (for example error flags) arrive on a vector input and are passed through only while awake.

Top module: `idle_wake_ctrl`

## Requirements
- R1: After reset the sleep bit, both sticky flags and all set pulses are 0.
- R2: After a character-complete pulse, the idle detection fires on the Nth bit tick with the line high, where N = 10 + nine_bit + two_stop (10, 11 or 12). The idle_set pulse is combinational with that tick, and no idle detection occurs on the earlier ticks.
- R3: A low line level in any cycle restarts the idle count from zero, so N further high ticks are needed.
- R4: Idle detection is armed only by a character-complete pulse and disarms when it fires. Ticks before the first character, or after a detection and before the next character, produce no idle_set.
- R5: A sleep_set strobe sets the sleep bit on the next clock edge. An idle detection clears it on the next clock edge.
- R6: When sleep_set and an idle detection fall in the same cycle, the sleep bit stays 1.
- R7: While the sleep bit is 1, rdy_set is 0 and every bit of aux_set is 0. While it is 0, rdy_set follows char_done and aux_set follows aux_evt.
- R8: With the sleep bit at 1 and wake_idle_cfg at 0, the idle detection that wakes the node gives no idle_set and leaves idle_flag at 0.
- R9: With wake_idle_cfg at 1, every idle detection gives idle_set, whatever the sleep bit. With the sleep bit at 0, every detection gives idle_set in either setting.
- R10: idle_flag and rdy_flag are set on the edge after their set pulse and hold until their own clear strobe. A set pulse in the same cycle as the clear strobe leaves the flag at 1.
- R11: After an automatic wake, the next character-complete pulse gives rdy_set and sets rdy_flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| line_lvl | input | 1 | Receive line level, 1 = idle |
| char_done | input | 1 | Pulse: a character has been received |
| nine_bit | input | 1 | 1 = nine data bits per character |
| two_stop | input | 1 | 1 = two stop bits |
| sleep_set | input | 1 | Strobe: put the receiver to sleep |
| wake_idle_cfg | input | 1 | 1 = report idle even while asleep |
| rdy_clr | input | 1 | Strobe: clear rdy_flag |
| idle_clr | input | 1 | Strobe: clear idle_flag |
| aux_evt | input | AUX_W | Other status set events from the receiver |
| sleep | output | 1 | Sleep bit |
| rdy_set | output | 1 | Gated data-ready set pulse |
| idle_set | output | 1 | Gated idle set pulse |
| aux_set | output | AUX_W | Gated other status set pulses |
| rdy_flag | output | 1 | Sticky data-ready flag |
| idle_flag | output | 1 | Sticky idle flag |

## Verification
A wrong idle count shows up at the ports at the end of the gap. idle_set appears one tick early or late, or does not appear at all, and the sleep bit falls one edge after that tick. So a count error in any of the three frame lengths is visible within twelve bit times of the character. A stuck arm bit shows up as a second idle_set on a line that is still idle. A wrong sleep state shows up in the same cycle as the next char_done or aux event, because rdy_set and aux_set are gated without a register. The four combinations of sleep and wake_idle_cfg are each driven through a full gap, so an error in the idle gating is caught on the waking tick.

// File: rtl/idle_wake_pkg.sv
// Shared types and helpers for the idle-line wakeup controller.
// Assumes a frame of start + data + stop bits whose length grows by one
// for nine-bit data and by one for a second stop bit.
package idle_wake_pkg;

    // Frame format selection as seen by the idle timer.
    typedef struct packed {
        logic nine_bit;
        logic two_stop;
    } frame_cfg_t;

    // Number of extra bit times the frame format adds to the base length.
    function automatic logic [1:0] frame_extra(input frame_cfg_t cfg);
        return {1'b0, cfg.nine_bit} + {1'b0, cfg.two_stop};
    endfunction

endpackage

// File: rtl/idle_timer.sv
// Idle gap timer.
// Counts bit ticks with the line high once a character has completed and
// pulses idle_hit on the tick that completes a full character time.
// Assumes bit_tick is a single-cycle pulse. A low line in any cycle restarts
// the count. A character-complete pulse re-arms and restarts, and wins over
// a tick in the same cycle.
module idle_timer
    import idle_wake_pkg::*;
#(
    parameter int unsigned BASE_BITS = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_tick,
    input  logic       line_lvl,
    input  logic       char_done,
    input  frame_cfg_t cfg,
    output logic       idle_hit
);
    localparam int unsigned CNT_W = $clog2(BASE_BITS + 3);

    logic             armed;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] target_m1;
    logic             at_last;

    // Last count value before the gap is complete, from the frame format.
    always_comb begin
        target_m1 = CNT_W'(BASE_BITS - 1) + CNT_W'(frame_extra(cfg));
        at_last   = (cnt == target_m1);
    end

    // Detection fires on the tick that would take the count to the target.
    assign idle_hit = armed & bit_tick & line_lvl & ~char_done & at_last;

    // Arm on a character, restart on a low line, advance on high-line ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (char_done) begin
            armed <= 1'b1;
            cnt   <= '0;
        end else if (!line_lvl) begin
            cnt   <= '0;
        end else if (armed && bit_tick) begin
            if (at_last) begin
                armed <= 1'b0;
                cnt   <= '0;
            end else begin
                cnt   <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/sleep_ctrl.sv
// Sleep bit register.
// Set by the software strobe, cleared by an idle detection. The strobe wins
// when both fall in the same cycle.
module sleep_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_set,
    input  logic idle_hit,
    output logic sleep
);

    // Hold the sleep state with set priority over automatic wake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sleep <= 1'b0;
        end else if (sleep_set) begin
            sleep <= 1'b1;
        end else if (idle_hit) begin
            sleep <= 1'b0;
        end
    end

endmodule

// File: rtl/flag_unit.sv
// Status gating and sticky flags.
// Blocks receiver set events while asleep, except idle when wake_idle_cfg
// is 1, and keeps sticky ready and idle flags where a set beats a clear.
// Assumes every input event is a single-cycle pulse.
module flag_unit #(
    parameter int unsigned AUX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep,
    input  logic             wake_idle_cfg,
    input  logic             char_done,
    input  logic             idle_hit,
    input  logic [AUX_W-1:0] aux_evt,
    input  logic             rdy_clr,
    input  logic             idle_clr,
    output logic             rdy_set,
    output logic             idle_set,
    output logic [AUX_W-1:0] aux_set,
    output logic             rdy_flag,
    output logic             idle_flag
);
    localparam int unsigned N_STICKY = 2;

    logic [N_STICKY-1:0] st_set;
    logic [N_STICKY-1:0] st_clr;
    logic [N_STICKY-1:0] st_q;

    // Gate the set events with the sleep state.
    always_comb begin
        rdy_set  = char_done & ~sleep;
        idle_set = idle_hit & (wake_idle_cfg | ~sleep);
    end

    // One gate per auxiliary status event.
    for (genvar g = 0; g < AUX_W; g++) begin : g_aux
        assign aux_set[g] = aux_evt[g] & ~sleep;
    end

    assign st_set = {idle_set, rdy_set};
    assign st_clr = {idle_clr, rdy_clr};

    // One sticky bit per flag, set has priority over clear.
    for (genvar f = 0; f < N_STICKY; f++) begin : g_sticky
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q[f] <= 1'b0;
            end else if (st_set[f]) begin
                st_q[f] <= 1'b1;
            end else if (st_clr[f]) begin
                st_q[f] <= 1'b0;
            end
        end
    end

    assign rdy_flag  = st_q[0];
    assign idle_flag = st_q[1];

endmodule

// File: rtl/idle_wake_ctrl.sv
// Idle-line wakeup controller, top level.
// Connects the idle gap timer, the sleep register and the flag gating.
// Assumes bit_tick, char_done and the strobes are single-cycle pulses
// synchronous to clk, and line_lvl is already synchronised.
module idle_wake_ctrl
    import idle_wake_pkg::*;
#(
    parameter int unsigned BASE_BITS = 10,
    parameter int unsigned AUX_W     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             line_lvl,
    input  logic             char_done,
    input  logic             nine_bit,
    input  logic             two_stop,
    input  logic             sleep_set,
    input  logic             wake_idle_cfg,
    input  logic             rdy_clr,
    input  logic             idle_clr,
    input  logic [AUX_W-1:0] aux_evt,
    output logic             sleep,
    output logic             rdy_set,
    output logic             idle_set,
    output logic [AUX_W-1:0] aux_set,
    output logic             rdy_flag,
    output logic             idle_flag
);
    frame_cfg_t cfg;
    logic       hit_w;

    assign cfg = '{nine_bit: nine_bit, two_stop: two_stop};

    idle_timer #(.BASE_BITS(BASE_BITS)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick  (bit_tick),
        .line_lvl  (line_lvl),
        .char_done (char_done),
        .cfg       (cfg),
        .idle_hit  (hit_w)
    );

    sleep_ctrl u_sleep (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_set (sleep_set),
        .idle_hit  (hit_w),
        .sleep     (sleep)
    );

    flag_unit #(.AUX_W(AUX_W)) u_flags (
        .clk           (clk),
        .rst_n         (rst_n),
        .sleep         (sleep),
        .wake_idle_cfg (wake_idle_cfg),
        .char_done     (char_done),
        .idle_hit      (hit_w),
        .aux_evt       (aux_evt),
        .rdy_clr       (rdy_clr),
        .idle_clr      (idle_clr),
        .rdy_set       (rdy_set),
        .idle_set      (idle_set),
        .aux_set       (aux_set),
        .rdy_flag      (rdy_flag),
        .idle_flag     (idle_flag)
    );

endmodule

// File: rtl/idle_wake_chk.sv
// Property checker for idle_wake_ctrl, attached with bind below.
// Relates the timer's detection to the sleep register and the gated outputs.
module idle_wake_chk #(
    parameter int unsigned AUX_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sleep_set,
    input logic             wake_idle_cfg,
    input logic             idle_clr,
    input logic             hit_w,
    input logic             sleep,
    input logic             rdy_set,
    input logic             idle_set,
    input logic [AUX_W-1:0] aux_set,
    input logic             idle_flag
);

    // R5
    sleep_on_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_set |=> sleep);

    // R5
    sleep_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sleep) |-> $past(hit_w));

    // R6
    set_beats_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_w && sleep_set) |=> sleep);

    // R7
    rdy_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !rdy_set);

    // R7
    aux_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> (aux_set == '0));

    // R8
    quiet_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep && !wake_idle_cfg) |-> !idle_set);

    // R9
    loud_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_w && wake_idle_cfg) |-> idle_set);

    // R10
    idle_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle_set |=> idle_flag);

    // R10
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_clr && !idle_set) |=> !idle_flag);

endmodule

bind idle_wake_ctrl idle_wake_chk #(.AUX_W(AUX_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sleep_set     (sleep_set),
    .wake_idle_cfg (wake_idle_cfg),
    .idle_clr      (idle_clr),
    .hit_w         (hit_w),
    .sleep         (sleep),
    .rdy_set       (rdy_set),
    .idle_set      (idle_set),
    .aux_set       (aux_set),
    .idle_flag     (idle_flag)
);

// File: tb/test_idle_wake_ctrl.sv
// Self-checking bench for idle_wake_ctrl. A vector table walks frame
// formats and sleep/wake-idle combinations, then directed corner tests.
module test_idle_wake_ctrl;
    localparam int unsigned AUX_W = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bit_tick = 1'b0;
    logic             line_lvl = 1'b1;
    logic             char_done = 1'b0;
    logic             nine_bit = 1'b0;
    logic             two_stop = 1'b0;
    logic             sleep_set = 1'b0;
    logic             wake_idle_cfg = 1'b0;
    logic             rdy_clr = 1'b0;
    logic             idle_clr = 1'b0;
    logic [AUX_W-1:0] aux_evt = '0;
    logic             sleep;
    logic             rdy_set;
    logic             idle_set;
    logic [AUX_W-1:0] aux_set;
    logic             rdy_flag;
    logic             idle_flag;

    int n_run = 0;
    int n_fail = 0;

    logic             c_idle;
    logic             c_rdy;
    logic [AUX_W-1:0] c_aux;

    always #2 clk = ~clk;

    idle_wake_ctrl #(.AUX_W(AUX_W)) i_idle_wake_ctrl (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .line_lvl(line_lvl),
        .char_done(char_done), .nine_bit(nine_bit), .two_stop(two_stop),
        .sleep_set(sleep_set), .wake_idle_cfg(wake_idle_cfg),
        .rdy_clr(rdy_clr), .idle_clr(idle_clr), .aux_evt(aux_evt),
        .sleep(sleep), .rdy_set(rdy_set), .idle_set(idle_set),
        .aux_set(aux_set), .rdy_flag(rdy_flag), .idle_flag(idle_flag)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock cycle of stimulus, called at a negedge; captures the
    // combinational pulses and returns at the next negedge.
    task automatic cyc(input logic tk, input logic lvl, input logic cd,
                       input logic ss, input logic ic, input logic rc,
                       input logic [AUX_W-1:0] ax);
        bit_tick = tk; line_lvl = lvl; char_done = cd; sleep_set = ss;
        idle_clr = ic; rdy_clr = rc; aux_evt = ax;
        #1;
        c_idle = idle_set; c_rdy = rdy_set; c_aux = aux_set;
        @(negedge clk);
        bit_tick = 1'b0; char_done = 1'b0; sleep_set = 1'b0;
        idle_clr = 1'b0; rdy_clr = 1'b0; aux_evt = '0;
    endtask

    task automatic tick_hi();
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    endtask

    // {nine_bit, two_stop, sleep first, wake_idle_cfg, expect idle_set}
    localparam logic [4:0] VEC [8] = '{
        5'b00_0_0_1, 5'b00_1_0_0, 5'b00_1_1_1, 5'b00_0_1_1,
        5'b10_0_0_1, 5'b01_1_0_0, 5'b11_0_0_1, 5'b11_1_1_1
    };

    initial begin : watchdog
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1 sleep", int'(sleep), 0);
        check("R1 flags", int'({rdy_flag, idle_flag}), 0);
        check("R1 pulses", int'({rdy_set, idle_set, aux_set}), 0);

        // R4: ticks before any character give no idle
        for (int i = 0; i < 14; i++) begin
            tick_hi();
            check("R4 unarmed", int'(c_idle), 0);
        end

        // Table walk: R2, R5, R7, R8, R9, R11
        foreach (VEC[v]) begin
            int tgt;
            nine_bit = VEC[v][4]; two_stop = VEC[v][3];
            wake_idle_cfg = VEC[v][1];
            tgt = 10 + int'(VEC[v][4]) + int'(VEC[v][3]);
            cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, '0);
            check("R10 cleared", int'({rdy_flag, idle_flag}), 0);
            if (VEC[v][2]) begin
                cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, '0);
                check("R5 sleep set", int'(sleep), 1);
            end
            cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0);
            check("R7 rdy gate", int'(c_rdy), int'(!VEC[v][2]));
            for (int i = 1; i <= tgt; i++) begin
                tick_hi();
                if (i < tgt) check("R2 early", int'(c_idle), 0);
                else check(VEC[v][2] ? (VEC[v][1] ? "R9 idle" : "R8 idle")
                                     : "R2 idle", int'(c_idle), int'(VEC[v][0]));
            end
            check("R5 woke", int'(sleep), 0);
            check("R10 idle flag", int'(idle_flag), int'(VEC[v][0]));
            // R11: next character after waking is reported
            cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0);
            check("R11 rdy_set", int'(c_rdy), 1);
            check("R11 rdy_flag", int'(rdy_flag), 1);
        end

        // R3: low line restarts the count (8-bit, 1 stop)
        nine_bit = 1'b0; two_stop = 1'b0; wake_idle_cfg = 1'b0;
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, '0);
        for (int i = 0; i < 6; i++) tick_hi();
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
        for (int i = 1; i <= 10; i++) begin
            tick_hi();
            check("R3 restart", int'(c_idle), (i == 10) ? 1 : 0);
        end
        // R4: continuing idle gives no further event
        for (int i = 0; i < 25; i++) begin
            tick_hi();
            check("R4 single event", int'(c_idle), 0);
        end

        // R6: sleep strobe on the waking tick keeps sleep at 1
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, '0);
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0);
        for (int i = 0; i < 9; i++) tick_hi();
        cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, '0);
        check("R8 no idle on wake", int'(c_idle), 0);
        check("R6 sleep held", int'(sleep), 1);

        // R7: auxiliary events blocked while asleep, passed when awake
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '1);
        check("R7 aux asleep", int'(c_aux), 0);
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0);
        for (int i = 0; i < 10; i++) tick_hi();
        check("R5 auto wake", int'(sleep), 0);
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b10);
        check("R7 aux awake", int'(c_aux), 2);

        // R10: set beats clear in the same cycle, then clear alone
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, '0);
        check("R10 set wins", int'(rdy_flag), 1);
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, '0);
        check("R10 clear", int'(rdy_flag), 0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule